// File: doc/BRIEF.md
# Serial Group Word Alignment Checker

This back-end block works out how a group of serial channels is misaligned when their bits are packed into one frame word per 40 MHz frame. The sending side first puts a rate-dependent marker on every channel so that the most significant bit of each channel can be located. It then sends a 4-bit LFSR sequence. The checker runs its own copy of that sequence and keeps the sixteen most recent local words. It compares each received frame against all sixteen at once, across every channel of the group. The lowest buffer position that matches is reported as the word offset of the group.

A frame that fails, either in the marker phase or in the sequence phase, raises a one-clock shift request. The sender answers it by moving its output by one whole bit. The checker then skips a programmable number of frames before it evaluates again. Once an offset is found it is latched and the checker stays silent until it is told to realign. The channel rate is a static input. It selects how many bits of each 8-bit channel slot are meaningful, which marker is expected, and how a local LFSR word is widened to a slot.

Top module: `galign_checker`

## Requirements
- R1: While reset is applied and after it is released, aligned is 0, offset is 0 and shift_req is 0.
- R2: The local sequence steps s -> {s[2:0], s[3]^s[2]} (x^4+x^3+1) from the seed parameter SEED (default 4'b0001; a zero seed is replaced by 4'b0001). It never holds the all-zero value.
- R3: Channel c occupies rx_word[8c+7:8c]. Rate code 0 (80 Mb/s) uses slot bits [1:0], code 1 (160 Mb/s) uses bits [3:0], and codes 2 and 3 (320 Mb/s) use all 8 bits. Unused slot bits have no effect.
- R4: After reset or realign the checker is in the marker phase. A frame in which every channel's used bits equal the marker (2'b10, 4'b1000 or 8'b1000_0000 for codes 0, 1, 2/3) moves it to the sequence phase from the next frame on, without any output change.
- R5: In the sequence phase, candidate k (0 to 15) is the local word from k frames before the current one. It is widened per rate to v[1:0], v[3:0] or {v,v}. Candidate k matches only when every channel of the group equals it.
- R6: On a matching frame, one clock after the strobe aligned is 1 and offset equals the lowest matching k. While aligned is 0, offset is 0.
- R7: A frame that fails its phase's check makes shift_req high for exactly one clock, one clock after the strobe.
- R8: After a shift request the next max(hold_frames,1) frames are not evaluated. The following frame is checked in the same phase that failed.
- R9: While aligned, offset is held, shift_req stays 0 and incoming frames have no effect.
- R10: One clock after realign is high, aligned and offset are 0 and the marker phase is active. Realign takes priority over a frame strobe in the same clock.
- R11: The local sequence advances exactly once per clock with frame_en high, in every phase, and never when frame_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_en | input | 1 | One received frame word is present this clock |
| realign | input | 1 | Drop the latched result and restart from the marker phase |
| rate | input | 2 | Channel rate code: 0 = 80, 1 = 160, 2 or 3 = 320 Mb/s |
| hold_frames | input | WAIT_W (8) | Frames skipped after a shift request (0 behaves as 1) |
| rx_word | input | NCH*8 (32) | Received group word, 8-bit slot per channel |
| aligned | output | 1 | Offset found and latched |
| offset | output | 4 | Lowest matching buffer index |
| shift_req | output | 1 | One-clock request for a one-bit shift at the sender |

## Verification
A local sequence that stepped on a clock without a strobe, or that started from the wrong place, would show up at the ports as a wrong offset on the very next match. The bench therefore places idle gaps between frames and checks offsets at several delays, including the 14 and 15 frame corners where the period wraps. A wait counter that is off by one appears one frame early or late as a missing or extra shift_req after a failing frame. A lost phase after realign shows up on the first frame that follows, as an alignment where a shift request was due. The reference model is compared with the outputs on every clock, so any such fault is reported within one frame of the strobe that exposes it.

// File: rtl/galign_pkg.sv
package galign_pkg;

  localparam int LFSR_W = 4;
  localparam int SLOT_W = 8;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = $clog2(DEPTH);

  typedef enum logic [2:0] {
    ST_MARK   = 3'd0,
    ST_HUNT   = 3'd1,
    ST_WAIT_M = 3'd2,
    ST_WAIT_H = 3'd3,
    ST_LOCK   = 3'd4
  } phase_t;

  // forward step, x^4 + x^3 + 1
  function automatic logic [LFSR_W-1:0] seq_fwd(input logic [LFSR_W-1:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  // inverse of seq_fwd
  function automatic logic [LFSR_W-1:0] seq_back(input logic [LFSR_W-1:0] n);
    return {n[0] ^ n[3], n[3:1]};
  endfunction

  function automatic logic [LFSR_W-1:0] seq_back_n(input logic [LFSR_W-1:0] s,
                                                   input int k);
    logic [LFSR_W-1:0] v;
    v = s;
    for (int i = 0; i < k; i++) v = seq_back(v);
    return v;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_mask(input logic [1:0] rate);
    case (rate)
      2'd0:    return 8'h03;
      2'd1:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_marker(input logic [1:0] rate);
    case (rate)
      2'd0:    return 8'h02;
      2'd1:    return 8'h08;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_pattern(input logic [LFSR_W-1:0] v,
                                                     input logic [1:0] rate);
    case (rate)
      2'd0:    return {6'd0, v[1:0]};
      2'd1:    return {4'd0, v};
      default: return {v, v};
    endcase
  endfunction

endpackage

// File: rtl/galign_seq_buf.sv
module galign_seq_buf
  import galign_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 4'b0001
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_en,
  output logic [DEPTH-1:0][LFSR_W-1:0]  words
);

  localparam logic [LFSR_W-1:0] SEED_OK = (SEED == '0) ? 4'b0001 : SEED;

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [DEPTH-1:0][LFSR_W-1:0] hist_q;

  always_comb begin
    lfsr_d = lfsr_q;
    if (frame_en) lfsr_d = seq_fwd(lfsr_q);
    if (lfsr_d == '0) lfsr_d = 4'b0001;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED_OK;
    else        lfsr_q <= lfsr_d;
  end

  assign hist_q[0] = lfsr_q;

  // entry k holds the word from k frames back; reset values run the
  // sequence backwards so the buffer is consistent from the first frame
  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_hist
      localparam logic [LFSR_W-1:0] INIT = seq_back_n(SEED_OK, k);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q[k] <= INIT;
        else if (frame_en) hist_q[k] <= hist_q[k-1];
      end
    end
  endgenerate

  assign words = hist_q;

  a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> $stable(lfsr_q));

  a_r11_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |=> hist_q[1] == $past(lfsr_q));

endmodule

// File: rtl/galign_compare.sv
module galign_compare
  import galign_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*SLOT_W-1:0]         rx_word,
  input  logic [1:0]                    rate,
  input  logic [DEPTH-1:0][LFSR_W-1:0]  words,
  output logic                          marker_ok,
  output logic                          match_any,
  output logic [IDX_W-1:0]              match_idx
);

  logic [SLOT_W-1:0] mask;
  logic [SLOT_W-1:0] marker;
  logic [NCH-1:0]    lane_mark;
  logic [DEPTH-1:0]  hit;

  assign mask   = slot_mask(rate);
  assign marker = slot_marker(rate);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_mark
      assign lane_mark[c] =
        ((rx_word[c*SLOT_W +: SLOT_W] ^ marker) & mask) == '0;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_pos
      logic [SLOT_W-1:0] pat;
      logic [NCH-1:0]    lane_hit;
      assign pat = slot_pattern(words[k], rate);
      for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign lane_hit[c] =
          ((rx_word[c*SLOT_W +: SLOT_W] ^ pat) & mask) == '0;
      end
      // whole group must agree
      assign hit[k] = &lane_hit;
    end
  endgenerate

  assign marker_ok = &lane_mark;
  assign match_any = |hit;

  always_comb begin
    match_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit[k]) match_idx = IDX_W'(k);
    end
  end

endmodule

// File: rtl/galign_ctrl.sv
module galign_ctrl
  import galign_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_en,
  input  logic              realign,
  input  logic [WAIT_W-1:0] hold_frames,
  input  logic              marker_ok,
  input  logic              match_any,
  input  logic [IDX_W-1:0]  match_idx,
  output logic              aligned,
  output logic [IDX_W-1:0]  offset,
  output logic              shift_req
);

  phase_t            st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              al_q, al_d;
  logic [IDX_W-1:0]  off_q, off_d;
  logic              sr_q, sr_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    al_d  = al_q;
    off_d = off_q;
    sr_d  = 1'b0;
    if (realign) begin
      st_d  = ST_MARK;
      cnt_d = '0;
      al_d  = 1'b0;
      off_d = '0;
    end else if (frame_en) begin
      case (st_q)
        ST_MARK: begin
          if (marker_ok) begin
            st_d = ST_HUNT;
          end else begin
            sr_d  = 1'b1;
            st_d  = ST_WAIT_M;
            cnt_d = hold_frames;
          end
        end
        ST_HUNT: begin
          if (match_any) begin
            st_d  = ST_LOCK;
            al_d  = 1'b1;
            off_d = match_idx;
          end else begin
            sr_d  = 1'b1;
            st_d  = ST_WAIT_H;
            cnt_d = hold_frames;
          end
        end
        ST_WAIT_M, ST_WAIT_H: begin
          if (cnt_q <= WAIT_W'(1)) begin
            st_d  = (st_q == ST_WAIT_M) ? ST_MARK : ST_HUNT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - WAIT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_MARK;
      cnt_q <= '0;
      al_q  <= 1'b0;
      off_q <= '0;
      sr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      al_q  <= al_d;
      off_q <= off_d;
      sr_q  <= sr_d;
    end
  end

  assign aligned   = al_q;
  assign offset    = off_q;
  assign shift_req = sr_q;

  a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q |=> !sr_q);

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (al_q && !realign) |=> (al_q && $stable(off_q)));

  a_r9_quiet_locked: assert property (@(posedge clk) disable iff (!rst_n)
    al_q |-> !sr_q);

  a_r10_realign_clears: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (!al_q && !sr_q && st_q == ST_MARK));

  a_r8_req_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q |-> (st_q == ST_WAIT_M || st_q == ST_WAIT_H));

endmodule

// File: rtl/galign_checker.sv
module galign_checker
  import galign_pkg::*;
#(
  parameter int                NCH    = 4,
  parameter int                WAIT_W = 8,
  parameter logic [LFSR_W-1:0] SEED   = 4'b0001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_en,
  input  logic                  realign,
  input  logic [1:0]            rate,
  input  logic [WAIT_W-1:0]     hold_frames,
  input  logic [NCH*SLOT_W-1:0] rx_word,
  output logic                  aligned,
  output logic [IDX_W-1:0]      offset,
  output logic                  shift_req
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DEPTH-1:0][LFSR_W-1:0] words;
  logic                         marker_ok;
  logic                         match_any;
  logic [IDX_W-1:0]             match_idx;

  galign_seq_buf #(.SEED(SEED)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .frame_en (frame_en),
    .words    (words)
  );

  galign_compare #(.NCH(NCH)) u_cmp (
    .rx_word   (rx_word),
    .rate      (rate),
    .words     (words),
    .marker_ok (marker_ok),
    .match_any (match_any),
    .match_idx (match_idx)
  );

  galign_ctrl #(.WAIT_W(WAIT_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_en    (frame_en),
    .realign     (realign),
    .hold_frames (hold_frames),
    .marker_ok   (marker_ok),
    .match_any   (match_any),
    .match_idx   (match_idx),
    .aligned     (aligned),
    .offset      (offset),
    .shift_req   (shift_req)
  );

  a_r6_offset_idle_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !aligned |-> offset == '0);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (!aligned && !shift_req));

endmodule

// File: tb/sim_galign_checker.sv
module sim_galign_checker;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int WAIT_W     = 8;
  localparam int W          = NCH * 8;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_en = 1'b0;
  logic          realign = 1'b0;
  logic [1:0]    rate = 2'd1;
  logic [WAIT_W-1:0] hold_frames = '0;
  logic [W-1:0]  rx_word = '0;
  logic          aligned;
  logic [3:0]    offset;
  logic          shift_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  galign_checker #(.NCH(NCH), .WAIT_W(WAIT_W), .SEED(4'b0001)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .realign(realign),
    .rate(rate), .hold_frames(hold_frames), .rx_word(rx_word),
    .aligned(aligned), .offset(offset), .shift_req(shift_req)
  );

  // ---------------- reference sequence (R2) ----------------
  int seq [15];
  initial begin
    int s;
    s = 1;
    for (int i = 0; i < 15; i++) begin
      seq[i] = s;
      s = ((s << 1) & 15) | (((s >> 3) ^ (s >> 2)) & 1);
    end
  end

  function automatic int seq_at(int t);
    return seq[((t % 15) + 15) % 15];
  endfunction

  function automatic int b_mask(int r);
    return (r == 0) ? 3 : (r == 1) ? 15 : 255;
  endfunction

  function automatic int b_marker(int r);
    return (r == 0) ? 2 : (r == 1) ? 8 : 128;
  endfunction

  function automatic int b_pat(int v, int r);
    return (r == 0) ? (v & 3) : (r == 1) ? v : (v | (v << 4));
  endfunction

  function automatic bit lanes_eq(logic [W-1:0] d, int p, int r);
    bit ok = 1;
    for (int c = 0; c < NCH; c++)
      if ((int'(d[c*8 +: 8]) & b_mask(r)) != (p & b_mask(r))) ok = 0;
    return ok;
  endfunction

  // lowest matching k, or -1
  function automatic int lowest_hit(logic [W-1:0] d, int t, int r);
    for (int k = 0; k < 16; k++)
      if (lanes_eq(d, b_pat(seq_at(t - k), r), r)) return k;
    return -1;
  endfunction

  // ---------------- cycle model ----------------
  // phase: 0 marker, 1 sequence, 2 wait->marker, 3 wait->sequence, 4 locked
  int m_ph = 0, m_cnt = 0, m_t = 0, m_off = 0;
  bit m_al = 0, m_sr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_t = 0; m_off = 0; m_al = 0; m_sr = 0;
    end else begin
      m_sr = 0;
      if (realign) begin
        m_ph = 0; m_al = 0; m_off = 0;
      end else if (frame_en) begin
        if (m_ph == 0) begin
          if (lanes_eq(rx_word, b_marker(int'(rate)), int'(rate))) m_ph = 1;
          else begin
            m_sr = 1; m_ph = 2;
            m_cnt = (hold_frames == 0) ? 1 : int'(hold_frames);
          end
        end else if (m_ph == 1) begin
          int h;
          h = lowest_hit(rx_word, m_t, int'(rate));
          if (h >= 0) begin m_ph = 4; m_al = 1; m_off = h; end
          else begin
            m_sr = 1; m_ph = 3;
            m_cnt = (hold_frames == 0) ? 1 : int'(hold_frames);
          end
        end else if (m_ph == 2 || m_ph == 3) begin
          m_cnt--;
          if (m_cnt == 0) m_ph = m_ph - 2;
        end
      end
      if (frame_en) m_t++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(aligned === m_al && offset === 4'(m_off), "R6", "aligned/offset",
            {27'd0, aligned, offset}, (int'(m_al) << 4) | m_off);
      check(shift_req === m_sr, "R7", "shift_req", int'(shift_req), int'(m_sr));
    end
  end

  // ---------------- stimulus ----------------
  int tb_t = 0;

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_en = 0; realign = 0;
    end
  endtask

  task automatic send(logic [W-1:0] d, bit re = 0);
    @(negedge clk);
    frame_en = 1; realign = re; rx_word = d;
    tb_t++;
    @(negedge clk);
    frame_en = 0; realign = 0;
  endtask

  function automatic logic [W-1:0] fill(int p, int junk);
    logic [W-1:0] d;
    for (int c = 0; c < NCH; c++) d[c*8 +: 8] = 8'(p | (junk << (c % 3)));
    return d;
  endfunction

  function automatic logic [W-1:0] seq_word(int dly, int r, int junk);
    return fill(b_pat(seq_at(tb_t - dly), r), junk);
  endfunction

  initial begin
    // R1 during reset
    idle(3);
    check(aligned === 0 && offset === 0 && shift_req === 0, "R1", "in reset",
          int'(aligned) + int'(offset) + int'(shift_req), 0);
    rst_n = 1;
    idle(5);
    check(aligned === 0 && offset === 0 && shift_req === 0, "R1", "after reset",
          int'(aligned) + int'(offset) + int'(shift_req), 0);

    // 160 Mb/s, failed marker, wait of 3 frames (R4 R7 R8)
    rate = 2'd1; hold_frames = 3;
    send(fill(0, 0));
    check(shift_req === 1, "R7", "req after bad marker", int'(shift_req), 1);
    for (int i = 0; i < 3; i++) begin
      send(fill(0, 0));
      check(shift_req === 0, "R8", "frame in wait ignored", int'(shift_req), 0);
    end
    send(fill(0, 0));
    check(shift_req === 1, "R8", "marker phase resumed", int'(shift_req), 1);
    idle(2);
    for (int i = 0; i < 3; i++) send(fill(0, 0));
    idle(3);                                   // R11: gaps do not step
    send(fill(8, 0));                          // R4 marker ok
    check(aligned === 0 && shift_req === 0, "R4", "marker accepted quietly",
          int'(aligned) + int'(shift_req), 0);
    idle(4);
    send(seq_word(5, 1, 0));                   // R5 delay 5
    check(aligned === 1 && offset === 4'd5, "R6", "offset 5 at 160", int'(offset), 5);

    // R9: frames ignored while locked
    send(fill(0, 0));
    send(fill(255, 0));
    check(aligned === 1 && offset === 4'd5 && shift_req === 0, "R9", "lock held",
          int'(offset), 5);

    // R10: realign with simultaneous good marker
    send(fill(8, 0), 1);
    check(aligned === 0 && offset === 0, "R10", "realign clears", int'(aligned), 0);
    send(seq_word(0, 1, 0));                   // in marker phase: must fail
    check(shift_req === 1 && aligned === 0, "R10", "back in marker phase",
          int'(shift_req), 1);

    // 80 Mb/s with junk in unused bits (R3), hold 0 acts as 1
    send(fill(0, 0), 1);
    rate = 2'd0; hold_frames = 0;
    send(fill(2, 60));
    check(shift_req === 0, "R3", "marker with junk accepted", int'(shift_req), 0);
    send(fill(0, 0));
    check(shift_req === (lowest_hit(fill(0, 0), tb_t - 1, 0) < 0), "R5",
          "80 rate compare", int'(shift_req), int'(lowest_hit(fill(0, 0), tb_t - 1, 0) < 0));
    idle(1);
    if (!aligned) begin
      send(fill(0, 0));                        // skipped frame (R8)
      send(seq_word(0, 0, 60));
      check(aligned === 1 && offset === 4'(lowest_hit(fill(b_pat(seq_at(tb_t - 1), 0), 0), tb_t - 1, 0)),
            "R3", "80 rate lock", int'(offset), 0);
    end

    // 320 Mb/s: group corruption, delay 14, wrap at 15 (R5)
    send(fill(0, 0), 1);
    rate = 2'd2; hold_frames = 2;
    send(fill(128, 0));
    begin
      logic [W-1:0] d;
      d = seq_word(3, 2, 0);
      d[15:8] = ~d[15:8];
      send(d);
      check(shift_req === 1 && aligned === 0, "R5", "one bad channel fails group",
            int'(shift_req), 1);
    end
    send(fill(0, 0)); send(fill(0, 0));
    send(seq_word(14, 2, 0));
    check(aligned === 1 && offset === 4'd14, "R5", "offset 14 at 320", int'(offset), 14);

    send(fill(0, 0), 1);
    rate = 2'd3;
    send(fill(128, 0));
    send(seq_word(15, 3, 0));
    check(aligned === 1 && offset === 4'd0, "R6", "delay 15 wraps to 0", int'(offset), 0);

    send(fill(0, 0), 1);
    send(fill(128, 0));
    idle(2);
    send(seq_word(9, 2, 0));
    check(aligned === 1 && offset === 4'd9, "R11", "offset 9 after gaps", int'(offset), 9);

    // R1 again: reset mid-lock
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(aligned === 0 && offset === 0 && shift_req === 0, "R1", "async reset",
          int'(aligned), 0);
    rst_n = 1;
    tb_t = 0;
    idle(5);
    rate = 2'd1;
    send(fill(8, 0));
    send(seq_word(2, 1, 0));
    check(aligned === 1 && offset === 4'd2, "R2", "sequence restarts at seed",
          int'(offset), 2);

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule